// File: doc/BRIEF.md
# Latched Dual Threshold Alarm Controller

This block watches two running totals supplied from outside: an elapsed-time count and an event count. Each total is compared with a programmable limit. A limit of zero switches its comparison off. A status flag for each source follows its comparison from cycle to cycle, so it rises when the total reaches its limit and drops again once the total falls back below it or the limit changes.

The block has one shared alarm pin, modelled as open drain. When a source whose enable bit is on meets its limit, the pin is pulled to its active level and stays there. It stays there even after the condition goes away, until the host sends a one-cycle clear strobe. If an enabled condition still holds when the clear arrives, the pin stays active and remains latched. A polarity bit picks the active level. Open drain is shown as a drive-enable output together with the level that would be driven. The counters themselves belong elsewhere. After reset the host holds the configuration and limit inputs at zero, so both alarms are off.

Top module: `dual_threshold_alarm`

## Requirements
- R1: `time_flag` goes to 1 one clock after an input cycle in which `time_limit` is nonzero and `time_count >= time_limit` (unsigned). After any other input cycle it goes to 0.
- R2: `event_flag` goes to 1 one clock after an input cycle in which `event_limit` is nonzero and `event_count >= event_limit` (unsigned). After any other input cycle it goes to 0.
- R3: A zero limit keeps that source's flag at 0 for every count value, including a count of zero. It also keeps that source from setting the alarm.
- R4: A flag clears by itself on the clock after its condition stops holding. No clear strobe is needed.
- R5: When a source's enable input is 1 and its condition holds in an input cycle, `alarm_oe` is 1 from the next clock on.
- R6: Once set, `alarm_oe` stays 1 on every later clock while `alarm_clear` is 0, whatever the counts and limits do.
- R7: An `alarm_clear` pulse in a cycle with no enabled condition true makes `alarm_oe` 0 from the next clock.
- R8: An `alarm_clear` pulse in a cycle where an enabled condition holds leaves `alarm_oe` at 1 on the next clock, latched again.
- R9: A source whose enable input is 0 never sets `alarm_oe`. Its flag still behaves as in R1 and R2.
- R10: `alarm_level` equals `alarm_active_high` in the same cycle: 1 means the pin is active high, 0 means active low. Active low is what the reset-time inputs of zero give.
- R11: While `rst` is high and on the first clock after it, `time_flag`, `event_flag` and `alarm_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| time_count | input | TIME_W | Accumulated elapsed-time total |
| time_limit | input | TIME_W | Elapsed-time threshold, 0 turns the comparison off |
| event_count | input | EVENT_W | Accumulated event total |
| event_limit | input | EVENT_W | Event threshold, 0 turns the comparison off |
| time_alarm_en | input | 1 | Lets the elapsed-time source set the alarm |
| event_alarm_en | input | 1 | Lets the event source set the alarm |
| alarm_active_high | input | 1 | Polarity of the pin: 1 active high, 0 active low |
| alarm_clear | input | 1 | One-cycle strobe that releases the latched alarm |
| time_flag | output | 1 | Live elapsed-time status flag |
| event_flag | output | 1 | Live event status flag |
| alarm_oe | output | 1 | Pin drive enable, 1 while the alarm is latched |
| alarm_level | output | 1 | Level driven on the pin while `alarm_oe` is 1 |

## Verification
Both flags and the latched drive enable are registered. Each one reflects the inputs of the cycle before, so it is due exactly one clock after its stimulus. The pin level is combinational and is due in the same cycle. The bench drives inputs at the falling edge. It advances its expected flag and latch state at the rising edge from those inputs, then compares at the next falling edge, before it drives anything new. Limits are sometimes zero and counts are placed just below, at and above the limit, so every check lands on one particular edge.

// File: rtl/dta_pkg.sv
package dta_pkg;

    typedef struct packed {
        logic time_en;
        logic event_en;
        logic active_high;
    } alarm_cfg_t;

    typedef struct packed {
        logic time_hit;
        logic event_hit;
    } src_vec_t;

    function automatic logic any_enabled(src_vec_t hits, alarm_cfg_t cfg);
        return (hits.time_hit & cfg.time_en) | (hits.event_hit & cfg.event_en);
    endfunction

endpackage

// File: rtl/dta_threshold_cmp.sv
module dta_threshold_cmp #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] limit,
    output logic             hit,
    output logic             flag
);
    localparam logic [WIDTH-1:0] OFF_LIMIT = '0;

    logic armed;

    always_comb begin
        armed = (limit != OFF_LIMIT);
        hit   = armed && (count >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= hit;
    end

    // Shared by both sources (R1 time, R2 event)
    assert_zero_disables_R3: assert property (@(posedge clk) disable iff (rst)
        (limit == OFF_LIMIT) |=> !flag);
    assert_flag_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (count < limit) |=> !flag);
    assert_flag_rises_R1: assert property (@(posedge clk) disable iff (rst)
        ((count >= limit) && (limit != OFF_LIMIT)) |=> flag);

endmodule

// File: rtl/dta_alarm_latch.sv
module dta_alarm_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clear_req,
    output logic latched
);
    always_ff @(posedge clk) begin
        if (rst) latched <= 1'b0;
        else     latched <= (clear_req ? 1'b0 : latched) | set_req;
    end

    assert_set_latches_R5: assert property (@(posedge clk) disable iff (rst)
        set_req |=> latched);
    assert_holds_without_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (latched && !clear_req) |=> latched);
    assert_clear_releases_R7: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !set_req) |=> !latched);

endmodule

// File: rtl/dta_pin_drive.sv
module dta_pin_drive
    import dta_pkg::*;
(
    input  logic       latched,
    input  alarm_cfg_t cfg,
    output logic       oe,
    output logic       level
);
    always_comb begin
        oe    = latched;
        level = cfg.active_high;
    end
endmodule

// File: rtl/dual_threshold_alarm.sv
module dual_threshold_alarm
    import dta_pkg::*;
#(
    parameter int TIME_W  = 32,
    parameter int EVENT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIME_W-1:0]  time_count,
    input  logic [TIME_W-1:0]  time_limit,
    input  logic [EVENT_W-1:0] event_count,
    input  logic [EVENT_W-1:0] event_limit,
    input  logic               time_alarm_en,
    input  logic               event_alarm_en,
    input  logic               alarm_active_high,
    input  logic               alarm_clear,
    output logic               time_flag,
    output logic               event_flag,
    output logic               alarm_oe,
    output logic               alarm_level
);
    alarm_cfg_t cfg;
    src_vec_t   hits;
    logic       set_req;
    logic       latched;

    always_comb begin
        cfg.time_en     = time_alarm_en;
        cfg.event_en    = event_alarm_en;
        cfg.active_high = alarm_active_high;
        set_req         = any_enabled(hits, cfg);
    end

    dta_threshold_cmp #(.WIDTH(TIME_W)) u_time_cmp (
        .clk   (clk),
        .rst   (rst),
        .count (time_count),
        .limit (time_limit),
        .hit   (hits.time_hit),
        .flag  (time_flag)
    );

    dta_threshold_cmp #(.WIDTH(EVENT_W)) u_event_cmp (
        .clk   (clk),
        .rst   (rst),
        .count (event_count),
        .limit (event_limit),
        .hit   (hits.event_hit),
        .flag  (event_flag)
    );

    dta_alarm_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .set_req   (set_req),
        .clear_req (alarm_clear),
        .latched   (latched)
    );

    dta_pin_drive u_drive (
        .latched (latched),
        .cfg     (cfg),
        .oe      (alarm_oe),
        .level   (alarm_level)
    );

    // R8: a clear that meets an enabled condition leaves the pin latched
    assert_clear_relatch_R8: assert property (@(posedge clk) disable iff (rst)
        (alarm_clear && ((hits.time_hit && time_alarm_en) || (hits.event_hit && event_alarm_en)))
        |=> alarm_oe);
    // R9: a rising drive enable needs a source that was enabled
    assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (!alarm_oe && !(time_alarm_en && hits.time_hit) && !(event_alarm_en && hits.event_hit))
        |=> !alarm_oe);

endmodule

// File: tb/dual_threshold_alarm_test.sv
module dual_threshold_alarm_test;
    localparam int TW = 32;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] time_count = '0, time_limit = '0;
    logic [EW-1:0] event_count = '0, event_limit = '0;
    logic          time_alarm_en = 0, event_alarm_en = 0, alarm_active_high = 0, alarm_clear = 0;
    logic          time_flag, event_flag, alarm_oe, alarm_level;

    int compared = 0;
    int mismatched = 0;
    logic exp_t = 0, exp_e = 0, exp_l = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_threshold_alarm #(.TIME_W(TW), .EVENT_W(EW)) uut (
        .clk(clk), .rst(rst),
        .time_count(time_count), .time_limit(time_limit),
        .event_count(event_count), .event_limit(event_limit),
        .time_alarm_en(time_alarm_en), .event_alarm_en(event_alarm_en),
        .alarm_active_high(alarm_active_high), .alarm_clear(alarm_clear),
        .time_flag(time_flag), .event_flag(event_flag),
        .alarm_oe(alarm_oe), .alarm_level(alarm_level)
    );

    function automatic logic meets(logic [TW-1:0] c, logic [TW-1:0] l);
        return (l != 0) && (c >= l);
    endfunction

    function automatic logic next_latch(logic cur, logic clr, logic th, logic eh, logic te, logic ee);
        return (clr ? 1'b0 : cur) | (th & te) | (eh & ee);
    endfunction

    task automatic check(string req, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, advance the model at the rising edge, compare at the next falling edge
    task automatic step(logic [TW-1:0] tc, logic [TW-1:0] tl, logic [EW-1:0] ec, logic [EW-1:0] el,
                        logic te, logic ee, logic pol, logic clr, string tag);
        logic th, eh;
        time_count = tc; time_limit = tl; event_count = ec; event_limit = el;
        time_alarm_en = te; event_alarm_en = ee; alarm_active_high = pol; alarm_clear = clr;
        th = meets(tc, tl);
        eh = meets({{(TW-EW){1'b0}}, ec}, {{(TW-EW){1'b0}}, el});
        #1 check({tag, " R10"}, alarm_level, pol);
        @(posedge clk);
        exp_l = next_latch(exp_l, clr, th, eh, te, ee);
        exp_t = th;
        exp_e = eh;
        @(negedge clk);
        check({tag, " R1"}, time_flag, exp_t);
        check({tag, " R2"}, event_flag, exp_e);
        check({tag, " R5"}, alarm_oe, exp_l);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check("R11 reset time_flag", time_flag, 1'b0);
        check("R11 reset event_flag", event_flag, 1'b0);
        check("R11 reset oe", alarm_oe, 1'b0);
        check("R10 reset level active low", alarm_level, 1'b0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11 after reset oe", alarm_oe, 1'b0);

        // R3: zero limits with zero and maximum counts
        step(0, 0, 0, 0, 1, 1, 0, 0, "R3 zero count");
        step('1, 0, '1, 0, 1, 1, 0, 0, "R3 max count");
        check("R3 oe stays off", alarm_oe, 1'b0);
        // R1 at, below and above the limit
        step(99, 100, 0, 0, 1, 0, 0, 0, "R1 below");
        step(100, 100, 0, 0, 1, 0, 0, 0, "R1 equal");
        check("R5 time sets oe", alarm_oe, 1'b1);
        // R4 self-clearing flag, R6 latch holds
        step(50, 100, 0, 0, 1, 0, 0, 0, "R4 drop");
        check("R4 flag cleared", time_flag, 1'b0);
        check("R6 latch held", alarm_oe, 1'b1);
        // R7 release
        step(50, 100, 0, 0, 1, 0, 0, 1, "R7 clear");
        check("R7 released", alarm_oe, 1'b0);
        // R2 and R8 relatch on the event source, active-high pin
        step(0, 0, 16'hFFFF, 16'hFFFF, 0, 1, 1, 0, "R2 equal");
        step(0, 0, 16'hFFFF, 16'hFFFF, 0, 1, 1, 1, "R8 clear with condition");
        check("R8 relatched", alarm_oe, 1'b1);
        // R9 disabled source sets flag only
        step(0, 0, 0, 0, 0, 0, 1, 1, "R9 release");
        step(500, 10, 20, 5, 0, 0, 1, 0, "R9 disabled");
        check("R9 flag set", time_flag, 1'b1);
        check("R9 oe off", alarm_oe, 1'b0);

        // Random phase: counts clustered around limits
        for (int i = 0; i < 3000; i++) begin
            logic [TW-1:0] tl, tc;
            logic [EW-1:0] el, ec;
            tl = ($urandom % 4 == 0) ? '0 : ($urandom % 64);
            el = ($urandom % 4 == 0) ? '0 : EW'($urandom % 64);
            tc = tl + TW'($urandom % 5) - TW'(2);
            ec = el + EW'($urandom % 5) - EW'(2);
            step(tc, tl, ec, el, 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 6 == 0), "random R6");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule